// File: doc/BRIEF.md
# Minimum-SAD Motion Vector Selector

This block sits behind a sum-of-absolute-differences engine in a block-matching motion estimator. For every candidate displacement of a 16x16 macroblock inside the search window, the engine delivers the sixteen 4x4 sub-block SADs together with the candidate's horizontal and vertical offset (dx, dy). The selector adds the sub-block SADs into four 8x8 partition SADs and one 16x16 SAD. For each of these 21 partitions it keeps the smallest SAD seen so far and the displacement that produced it.

A search is a run of candidates opened by one flagged first and closed by one flagged last. When the closing candidate has been taken in, a one-cycle done pulse tells the consumer that all 21 best SADs and motion vectors are final. They then stay unchanged until the next search opens. The candidate input is a valid/ready stream. Ready is held high at all times, so the block never applies back-pressure: every cycle with valid high delivers one candidate, and the block can take a candidate on every clock.

Top module: `mv_min_select`

## Requirements
- R1: While reset is asserted and after it, before any accepted candidate, every best SAD output is all ones, every motion vector output is zero, and done is low.
- R2: in_ready is high in every cycle out of reset. A candidate is taken on each rising edge where in_valid is high, with no gap needed between candidates.
- R3: Each sub-block k (0..15) keeps its own minimum, in best_sad4[k*SAD_W +: SAD_W]. A candidate replaces it only if the candidate's SAD is strictly smaller, so a tie keeps the earlier motion vector. Each motion vector is packed as {dy, dx}, with dx in the low MV_W bits, and sub-block k's vector is in best_mv4[k*2*MV_W +: 2*MV_W].
- R4: 8x8 partition q (0..3) has a SAD equal to the sum of sub-blocks base, base+1, base+4 and base+5, where base = (q/2)*8 + (q%2)*2. Partition 0 is therefore 0+1+4+5. Its minimum is tracked with the same strict-less rule and sits in slot q of best_sad8 and best_mv8.
- R5: The 16x16 SAD is the sum of all sixteen sub-block SADs. Its minimum and vector are tracked with the strict-less rule in best_sad16 and best_mv16.
- R6: A candidate flagged first loads all 21 minima and vectors unconditionally, whatever they held before.
- R7: A candidate with dx outside -SX..+SX or dy outside -SY..+SY (signed, inclusive bounds) is discarded entirely. Its SADs, its first flag and its last flag have no effect.
- R8: done is high for exactly the one cycle after the rising edge that took an in-range candidate flagged last. Candidates that are not flagged first are then ignored until the next first, so the outputs hold. A candidate flagged both first and last forms a complete one-candidate search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A candidate is presented this cycle |
| in_ready | output | 1 | Always high; the block never stalls the stream |
| in_first | input | 1 | Candidate opens a new search |
| in_last | input | 1 | Candidate closes the search |
| in_dx | input | MV_W | Signed horizontal displacement |
| in_dy | input | MV_W | Signed vertical displacement |
| in_sad | input | 16*SAD_W | Sixteen 4x4 SADs, sub-block k at bits k*SAD_W |
| best_sad4 | output | 16*SAD_W | Best SAD per 4x4 sub-block |
| best_mv4 | output | 32*MV_W | Best {dy,dx} per 4x4 sub-block |
| best_sad8 | output | 4*(SAD_W+2) | Best SAD per 8x8 partition |
| best_mv8 | output | 8*MV_W | Best {dy,dx} per 8x8 partition |
| best_sad16 | output | SAD_W+4 | Best 16x16 SAD |
| best_mv16 | output | 2*MV_W | Best 16x16 {dy,dx} |
| done | output | 1 | One-cycle pulse: results of the search are final |

## Verification
A tracker that holds a wrong minimum shows up at the ports one cycle after the edge that took the offending candidate. The reason is that every best SAD and vector is a register that drives an output directly. Errors in how sub-blocks are grouped or in the tie rule stay invisible until a candidate arrives whose partition sum, or exactly equal SAD, exposes them. For that reason the stimulus mixes wide-range SADs with narrow-range ones that make ties frequent. An error in the session state, such as a missed window close or an out-of-range candidate that gets through, shows up as a changed output or a stray done pulse in the cycle after that candidate.

// File: rtl/mvsel_pkg.sv
package mvsel_pkg;
  localparam int NSUB = 16;   // 4x4 sub-blocks in one macroblock
  localparam int NQ   = 4;    // 8x8 partitions
  localparam int GRID = 4;    // sub-blocks per row

  // sub-block index of member m (0..3) of 8x8 partition q
  function automatic int quad_member(input int q, input int m);
    int base;
    base = (q / 2) * (2 * GRID) + (q % 2) * 2;
    return base + (m % 2) + (m / 2) * GRID;
  endfunction
endpackage

// File: rtl/mvsel_range.sv
module mvsel_range #(
  parameter int MV_W = 6,
  parameter int SX   = 16,
  parameter int SY   = 16
) (
  input  logic signed [MV_W-1:0] dx,
  input  logic signed [MV_W-1:0] dy,
  output logic                   ok
);
  localparam int signed XLO = -SX;
  localparam int signed XHI = SX;
  localparam int signed YLO = -SY;
  localparam int signed YHI = SY;

  logic signed [31:0] dxe, dye;
  assign dxe = 32'(dx);
  assign dye = 32'(dy);
  assign ok  = (dxe >= XLO) && (dxe <= XHI) && (dye >= YLO) && (dye <= YHI);
endmodule

// File: rtl/mvsel_merge.sv
module mvsel_merge
  import mvsel_pkg::*;
#(
  parameter int SAD_W = 12
) (
  input  logic [NSUB*SAD_W-1:0]   sub_sad,
  output logic [NQ*(SAD_W+2)-1:0] quad_sad,
  output logic [SAD_W+3:0]        mb_sad
);
  localparam int QW = SAD_W + 2;
  localparam int MW = SAD_W + 4;

  logic [QW-1:0] q_sum [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_quad
    localparam int I0 = quad_member(q, 0);
    localparam int I1 = quad_member(q, 1);
    localparam int I2 = quad_member(q, 2);
    localparam int I3 = quad_member(q, 3);
    assign q_sum[q] = QW'(sub_sad[I0*SAD_W +: SAD_W]) + QW'(sub_sad[I1*SAD_W +: SAD_W])
                    + QW'(sub_sad[I2*SAD_W +: SAD_W]) + QW'(sub_sad[I3*SAD_W +: SAD_W]);
    assign quad_sad[q*QW +: QW] = q_sum[q];
  end

  assign mb_sad = MW'(q_sum[0]) + MW'(q_sum[1]) + MW'(q_sum[2]) + MW'(q_sum[3]);
endmodule

// File: rtl/mvsel_track.sv
module mvsel_track #(
  parameter int W    = 12,
  parameter int MV_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            load,
  input  logic [W-1:0]    sad,
  input  logic [2*MV_W-1:0] mv,
  output logic [W-1:0]    best_sad,
  output logic [2*MV_W-1:0] best_mv
);
  logic better;
  assign better = sad < best_sad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_sad <= '1;
      best_mv  <= '0;
    end else if (take && (load || better)) begin
      best_sad <= sad;
      best_mv  <= mv;
    end
  end
endmodule

// File: rtl/mv_min_select.sv
module mv_min_select
  import mvsel_pkg::*;
#(
  parameter int SAD_W = 12,
  parameter int MV_W  = 6,
  parameter int SX    = 16,
  parameter int SY    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_first,
  input  logic                      in_last,
  input  logic signed [MV_W-1:0]    in_dx,
  input  logic signed [MV_W-1:0]    in_dy,
  input  logic [NSUB*SAD_W-1:0]     in_sad,
  output logic [NSUB*SAD_W-1:0]     best_sad4,
  output logic [NSUB*2*MV_W-1:0]    best_mv4,
  output logic [NQ*(SAD_W+2)-1:0]   best_sad8,
  output logic [NQ*2*MV_W-1:0]      best_mv8,
  output logic [SAD_W+3:0]          best_sad16,
  output logic [2*MV_W-1:0]         best_mv16,
  output logic                      done
);
  localparam int QW  = SAD_W + 2;
  localparam int MW  = SAD_W + 4;
  localparam int VW  = 2 * MV_W;

  logic            in_ok;
  logic            open_q;
  logic            take;
  logic            load;
  logic [VW-1:0]   cand_mv;
  logic [NQ*QW-1:0] quad_sad;
  logic [MW-1:0]   mb_sad;

  assign in_ready = 1'b1;
  assign cand_mv  = {in_dy, in_dx};

  mvsel_range #(.MV_W(MV_W), .SX(SX), .SY(SY)) u_range (
    .dx(in_dx), .dy(in_dy), .ok(in_ok)
  );

  // a candidate counts when in range and inside an open search (or opening one)
  assign take = in_valid && in_ready && in_ok && (in_first || open_q);
  assign load = in_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= take && in_last;
      if (take && in_last)       open_q <= 1'b0;
      else if (take && in_first) open_q <= 1'b1;
    end
  end

  mvsel_merge #(.SAD_W(SAD_W)) u_merge (
    .sub_sad(in_sad), .quad_sad(quad_sad), .mb_sad(mb_sad)
  );

  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    mvsel_track #(.W(SAD_W), .MV_W(MV_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .take(take), .load(load),
      .sad(in_sad[k*SAD_W +: SAD_W]), .mv(cand_mv),
      .best_sad(best_sad4[k*SAD_W +: SAD_W]), .best_mv(best_mv4[k*VW +: VW])
    );
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    mvsel_track #(.W(QW), .MV_W(MV_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .take(take), .load(load),
      .sad(quad_sad[q*QW +: QW]), .mv(cand_mv),
      .best_sad(best_sad8[q*QW +: QW]), .best_mv(best_mv8[q*VW +: VW])
    );
  end

  mvsel_track #(.W(MW), .MV_W(MV_W)) u_trk_mb (
    .clk(clk), .rst_n(rst_n), .take(take), .load(load),
    .sad(mb_sad), .mv(cand_mv),
    .best_sad(best_sad16), .best_mv(best_mv16)
  );
endmodule

// File: rtl/mv_min_select_chk.sv
module mv_min_select_chk #(
  parameter int SAD_W = 12,
  parameter int MV_W  = 6,
  parameter int SX    = 16,
  parameter int SY    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_first,
  input logic                   in_last,
  input logic signed [MV_W-1:0] in_dx,
  input logic signed [MV_W-1:0] in_dy,
  input logic [16*SAD_W-1:0]    best_sad4,
  input logic [32*MV_W-1:0]     best_mv4,
  input logic [4*(SAD_W+2)-1:0] best_sad8,
  input logic [SAD_W+3:0]       best_sad16,
  input logic [2*MV_W-1:0]      best_mv16,
  input logic                   done
);
  logic c_ok;
  assign c_ok = (int'(in_dx) >= -SX) && (int'(in_dx) <= SX) &&
                (int'(in_dy) >= -SY) && (int'(in_dy) <= SY);

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) in_ready); // R2
  AST_SUB_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_first) |=> best_sad4[SAD_W-1:0] <= $past(best_sad4[SAD_W-1:0])); // R3
  AST_QUAD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_first) |=> best_sad8[SAD_W+1:0] <= $past(best_sad8[SAD_W+1:0])); // R4
  AST_MB_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_first) |=> best_sad16 <= $past(best_sad16)); // R5
  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && c_ok) |=> best_mv16 == $past({in_dy, in_dx})); // R6
  AST_OUT_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !c_ok) |=> ($stable(best_sad16) && $stable(best_mv4) && !done)); // R7
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last && c_ok)); // R8
endmodule

bind mv_min_select mv_min_select_chk #(.SAD_W(SAD_W), .MV_W(MV_W), .SX(SX), .SY(SY)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_first(in_first), .in_last(in_last), .in_dx(in_dx), .in_dy(in_dy),
  .best_sad4(best_sad4), .best_mv4(best_mv4), .best_sad8(best_sad8),
  .best_sad16(best_sad16), .best_mv16(best_mv16), .done(done)
);

// File: tb/mv_min_select_test.sv
`timescale 1ns/1ps
module mv_min_select_test;
  localparam int SAD_W = 12;
  localparam int MV_W  = 6;
  localparam int SX    = 16;
  localparam int SY    = 16;
  localparam int QW    = SAD_W + 2;
  localparam int VW    = 2 * MV_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic in_ready;
  logic signed [MV_W-1:0] in_dx = '0, in_dy = '0;
  logic [16*SAD_W-1:0] in_sad = '0;
  logic [16*SAD_W-1:0] best_sad4;
  logic [32*MV_W-1:0]  best_mv4;
  logic [4*QW-1:0]     best_sad8;
  logic [8*MV_W-1:0]   best_mv8;
  logic [SAD_W+3:0]    best_sad16;
  logic [VW-1:0]       best_mv16;
  logic done;

  always #2.5 clk = ~clk;

  mv_min_select #(.SAD_W(SAD_W), .MV_W(MV_W), .SX(SX), .SY(SY)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_dx(in_dx), .in_dy(in_dy),
    .in_sad(in_sad), .best_sad4(best_sad4), .best_mv4(best_mv4),
    .best_sad8(best_sad8), .best_mv8(best_mv8), .best_sad16(best_sad16),
    .best_mv16(best_mv16), .done(done)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  int cur[16];
  int m_s4[16], m_x4[16], m_y4[16];
  int m_s8[4], m_x8[4], m_y8[4];
  int m_s16, m_x16, m_y16;
  bit m_open, m_done;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int sx(input logic [MV_W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 16; k++) begin m_s4[k] = 4095; m_x4[k] = 0; m_y4[k] = 0; end
    for (int q = 0; q < 4; q++) begin m_s8[q] = 16383; m_x8[q] = 0; m_y8[q] = 0; end
    m_s16 = 65535; m_x16 = 0; m_y16 = 0; m_open = 0; m_done = 0;
  endtask

  task automatic compare_all();
    for (int k = 0; k < 16; k++) begin
      int a = int'(best_sad4[k*SAD_W +: SAD_W]);
      int ax = sx(best_mv4[k*VW +: MV_W]);
      int ay = sx(best_mv4[k*VW+MV_W +: MV_W]);
      chk(a == m_s4[k], "R3", $sformatf("sad4[%0d]", k), a, m_s4[k]);
      chk(ax == m_x4[k] && ay == m_y4[k], "R3", $sformatf("mv4[%0d] dx*64+dy", k),
          ax*64+ay, m_x4[k]*64+m_y4[k]);
    end
    for (int q = 0; q < 4; q++) begin
      int a = int'(best_sad8[q*QW +: QW]);
      int ax = sx(best_mv8[q*VW +: MV_W]);
      int ay = sx(best_mv8[q*VW+MV_W +: MV_W]);
      chk(a == m_s8[q], "R4", $sformatf("sad8[%0d]", q), a, m_s8[q]);
      chk(ax == m_x8[q] && ay == m_y8[q], "R4", $sformatf("mv8[%0d] dx*64+dy", q),
          ax*64+ay, m_x8[q]*64+m_y8[q]);
    end
    chk(int'(best_sad16) == m_s16, "R5", "sad16", int'(best_sad16), m_s16);
    chk(sx(best_mv16[MV_W-1:0]) == m_x16 && sx(best_mv16[VW-1:MV_W]) == m_y16, "R5",
        "mv16 dx*64+dy", sx(best_mv16[MV_W-1:0])*64+sx(best_mv16[VW-1:MV_W]), m_x16*64+m_y16);
    chk(done == m_done, "R8", "done", int'(done), int'(m_done));
    chk(in_ready == 1'b1, "R2", "in_ready", int'(in_ready), 1);
  endtask

  // drive one cycle of input, advance model, check after the edge
  task automatic step(input bit v, input bit f, input bit l, input int dx, input int dy);
    bit ok, acc;
    in_valid = v; in_first = f; in_last = l;
    in_dx = MV_W'(dx); in_dy = MV_W'(dy);
    for (int k = 0; k < 16; k++) in_sad[k*SAD_W +: SAD_W] = SAD_W'(cur[k]);
    ok  = (dx >= -SX) && (dx <= SX) && (dy >= -SY) && (dy <= SY);
    acc = v && ok && (f || m_open);
    m_done = acc && l;
    if (acc) begin
      int tot = 0;
      for (int k = 0; k < 16; k++) begin
        tot += cur[k];
        if (f || cur[k] < m_s4[k]) begin m_s4[k] = cur[k]; m_x4[k] = dx; m_y4[k] = dy; end
      end
      for (int q = 0; q < 4; q++) begin
        int b = (q / 2) * 8 + (q % 2) * 2;
        int s = cur[b] + cur[b+1] + cur[b+4] + cur[b+5];
        if (f || s < m_s8[q]) begin m_s8[q] = s; m_x8[q] = dx; m_y8[q] = dy; end
      end
      if (f || tot < m_s16) begin m_s16 = tot; m_x16 = dx; m_y16 = dy; end
      if (l) m_open = 0; else if (f) m_open = 1;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic fill(input int maxv);
    for (int k = 0; k < 16; k++) cur[k] = $urandom_range(maxv, 0);
  endtask

  task automatic fill_const(input int v);
    for (int k = 0; k < 16; k++) cur[k] = v;
  endtask

  task automatic search(input int n, input int maxv, input bit gaps);
    for (int i = 0; i < n; i++) begin
      int dx = $urandom_range(40, 0) - 20;
      int dy = $urandom_range(40, 0) - 20;
      if (i == 0 || i == n-1) begin
        dx = $urandom_range(32, 0) - 16;
        dy = $urandom_range(32, 0) - 16;
      end
      fill(maxv);
      if (gaps && ($urandom_range(3, 0) == 0)) step(0, 0, 0, dx, dy);
      step(1, i == 0, i == n-1, dx, dy);
    end
  endtask

  initial begin
    void'($urandom(7));
    model_reset();
    fill_const(0);
    repeat (3) @(negedge clk);
    // R1: reset values
    compare_all();
    chk(best_sad16 == '1, "R1", "sad16 at reset", int'(best_sad16), 65535);
    chk(done == 1'b0, "R1", "done at reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    chk(best_mv4 == '0, "R1", "mv4 after reset", 0, 0);

    // main search with small SADs: gets ties often (R3 tie rule)
    search(40, 20, 0);
    // R6: first candidate with large SADs still loads
    fill_const(4000);
    step(1, 1, 0, 3, -2);
    chk(int'(best_sad16) == 64000 && sx(best_mv16[MV_W-1:0]) == 3, "R6", "first load sad16",
        int'(best_sad16), 64000);
    // R3 tie: same SADs, other vector, must keep (3,-2)
    step(1, 0, 0, 5, 5);
    chk(sx(best_mv4[MV_W-1:0]) == 3, "R3", "tie keeps earlier dx", sx(best_mv4[MV_W-1:0]), 3);
    // R7: out of range, smaller SADs, carrying last: ignored
    fill_const(1);
    step(1, 0, 1, 17, 0);
    chk(int'(best_sad16) == 64000 && done == 0, "R7", "dx=17 ignored", int'(best_sad16), 64000);
    step(1, 0, 1, 0, -17);
    chk(int'(best_sad16) == 64000 && done == 0, "R7", "dy=-17 ignored", int'(best_sad16), 64000);
    // edge of range accepted, closes search
    step(1, 0, 1, -16, 16);
    chk(int'(best_sad16) == 16 && done == 1, "R8", "last at range edge", int'(best_sad16), 16);
    // R8: after last, non-first candidate ignored; done a single pulse
    fill_const(0);
    step(1, 0, 0, 1, 1);
    chk(int'(best_sad16) == 16 && done == 0, "R8", "closed search holds", int'(best_sad16), 16);
    // R8: first and last together
    fill_const(9);
    step(1, 1, 1, -1, 2);
    chk(done == 1 && int'(best_sad16) == 144, "R8", "single-candidate search", int'(best_sad16), 144);
    step(0, 0, 0, 0, 0);
    chk(done == 0, "R8", "done one cycle", int'(done), 0);

    // randomized sessions, wide and narrow SAD ranges, with idle gaps (R2..R8)
    for (int s = 0; s < 30; s++) search($urandom_range(60, 1), (s % 2) ? 4095 : 6, 1);
    // back-to-back searches without idle
    for (int s = 0; s < 10; s++) search(8, 100, 0);
    step(0, 0, 0, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule